// File: doc/BRIEF.md
# Multi-color background collision detector

This block decides, pixel by pixel, whether a sprite being drawn into a 16-color palettized framebuffer overlaps existing foreground content. It holds a mask with one bit per color index. A set bit marks that index as background. On each cycle with a valid strobe, it receives the color index of the sprite pixel and the color index already stored at the destination. The destination index is the one read before the new pixel overwrites it.

A pixel pair collides only when neither of its two indexes is marked as background. The block reports each colliding pair on a per-pixel output one cycle later. It also keeps a sticky flag that covers a whole sprite draw and is cleared when a new draw starts.

The mask can be written in three ways:
- A full-width load from a register.
- A legacy one-color command that keeps exactly one background index.
- Byte writes on a small memory-mapped window of two consecutive addresses.

The mask has no read path. Software sees its effect only through collisions.

Top module: `bgmask_collide`

## Requirements
- R1: After reset the mask is 0x0001, so only color index 0 is background. Both `pix_hit` and `collided` are 0.
- R2: Bit i of the mask marks color index i as background when it is 1. A pair collides exactly when `pix_valid` is 1 and both the mask bit of `src_idx` and the mask bit of `dst_idx` are 0. `pix_hit` shows this result one cycle after the pair is presented. `pix_hit` is 0 after any cycle with `pix_valid` at 0.
- R3: When `mask_ld` is 1, the whole mask takes the value of `mask_ld_data` from the next cycle on.
- R4: When `legacy_ld` is 1 and `mask_ld` is 0, the mask becomes a word with only bit `legacy_idx` set and all other bits cleared.
- R5: When `mm_we` is 1 and neither load command is active, a write to address 0xFFF4 replaces mask bits 7..0 with `mm_wdata`. A write to address 0xFFF5 replaces mask bits 15..8. The other byte keeps its value.
- R6: A memory-mapped write to any other address leaves the mask unchanged.
- R7: `collided` is cleared by `draw_start`. It becomes 1 once any valid pair collides and stays 1 until the next `draw_start`. A pair presented in the same cycle as `draw_start` counts toward the new draw.
- R8: When several write paths are active in one cycle, `mask_ld` wins over `legacy_ld`, and `legacy_ld` wins over `mm_we`. A pair presented in the same cycle as a mask write is judged with the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_ld | input | 1 | Load the whole mask from `mask_ld_data` |
| mask_ld_data | input | 16 | Full mask value |
| legacy_ld | input | 1 | Legacy one-background-color command |
| legacy_idx | input | 4 | Index that becomes the only background color |
| mm_we | input | 1 | Memory-mapped byte write strobe |
| mm_addr | input | 16 | Memory-mapped byte address |
| mm_wdata | input | 8 | Memory-mapped byte data |
| draw_start | input | 1 | Start of a sprite draw; clears the sticky flag |
| pix_valid | input | 1 | A pixel pair is presented this cycle |
| src_idx | input | 4 | Sprite pixel color index |
| dst_idx | input | 4 | Framebuffer color index before the overwrite |
| pix_hit | output | 1 | Pair from the previous cycle collided |
| collided | output | 1 | Sticky collision flag for the current draw |

## Verification
The bench sweeps all 256 index pairs under several masks. This catches a design that tests only one side of the pair, or treats a set bit as foreground. It writes each mask byte alone and also hits neighbouring addresses. A swapped byte lane, a write that also clears the other byte, or a loose address decode would then change which pairs collide. It also drives simultaneous writes and a pair in the same cycle as a write, which exposes a wrong priority or a mask used one cycle early. Draws are started with and without a colliding first pixel, which shows whether the sticky flag clears late or drops the pixel from the start cycle.

// File: rtl/bgmask_collide.sv
module bgmask_collide #(
  parameter int          IDX_W     = 4,
  parameter int          AW        = 16,
  parameter logic [15:0] BASE_ADDR = 16'hFFF4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mask_ld,
  input  logic [(1<<IDX_W)-1:0]   mask_ld_data,
  input  logic                    legacy_ld,
  input  logic [IDX_W-1:0]        legacy_idx,
  input  logic                    mm_we,
  input  logic [AW-1:0]           mm_addr,
  input  logic [7:0]              mm_wdata,
  input  logic                    draw_start,
  input  logic                    pix_valid,
  input  logic [IDX_W-1:0]        src_idx,
  input  logic [IDX_W-1:0]        dst_idx,
  output logic                    pix_hit,
  output logic                    collided
);
  localparam int NCOL  = 1 << IDX_W;
  localparam int NBYTE = NCOL / 8;

  logic [NCOL-1:0] mask_q, mask_d;
  logic            pair_fg;

  assign pair_fg = pix_valid & ~mask_q[src_idx] & ~mask_q[dst_idx];

  always_comb begin
    mask_d = mask_q;
    if (mask_ld) begin
      mask_d = mask_ld_data;
    end else if (legacy_ld) begin
      mask_d = '0;
      mask_d[legacy_idx] = 1'b1;
    end else if (mm_we) begin
      for (int k = 0; k < NBYTE; k++)
        if (mm_addr == AW'(BASE_ADDR + 16'(k)))
          mask_d[k*8 +: 8] = mm_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= NCOL'(1);
      pix_hit  <= 1'b0;
      collided <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      pix_hit  <= pair_fg;
      collided <= (collided & ~draw_start) | pair_fg;
    end
  end
endmodule

// File: rtl/bgmask_collide_chk.sv
module bgmask_collide_chk #(
  parameter int          IDX_W     = 4,
  parameter int          AW        = 16,
  parameter logic [15:0] BASE_ADDR = 16'hFFF4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mask_ld,
  input logic [(1<<IDX_W)-1:0] mask_ld_data,
  input logic                  legacy_ld,
  input logic [IDX_W-1:0]      legacy_idx,
  input logic                  mm_we,
  input logic [AW-1:0]         mm_addr,
  input logic [7:0]            mm_wdata,
  input logic                  draw_start,
  input logic                  pix_valid,
  input logic [IDX_W-1:0]      src_idx,
  input logic [IDX_W-1:0]      dst_idx,
  input logic                  pix_hit,
  input logic                  collided,
  input logic [(1<<IDX_W)-1:0] mask_q
);
  localparam int NCOL = 1 << IDX_W;
  logic lo_hit, hi_hit;
  assign lo_hit = mm_addr == AW'(BASE_ADDR);
  assign hi_hit = mm_addr == AW'(BASE_ADDR + 16'd1);

  assert_reset_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == NCOL'(1)));

  assert_bg_never_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid || mask_q[src_idx] || mask_q[dst_idx]) |=> !pix_hit);

  assert_fg_pair_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !mask_q[src_idx] && !mask_q[dst_idx]) |=> pix_hit);

  assert_full_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_ld |=> (mask_q == $past(mask_ld_data)));

  assert_legacy_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_ld && legacy_ld) |=> ($countones(mask_q) == 1 && mask_q[$past(legacy_idx)]));

  assert_low_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_ld && !legacy_ld && mm_we && lo_hit)
      |=> (mask_q[7:0] == $past(mm_wdata) && $stable(mask_q[NCOL-1:8])));

  assert_other_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_ld && !legacy_ld && (!mm_we || (!lo_hit && !hi_hit))) |=> $stable(mask_q));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (collided && !draw_start) |=> collided);

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (draw_start && !pix_valid) |=> !collided);
endmodule

bind bgmask_collide bgmask_collide_chk #(.IDX_W(IDX_W), .AW(AW), .BASE_ADDR(BASE_ADDR)) u_chk (.*);

// File: tb/bgmask_collide_bench.sv
module bgmask_collide_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mask_ld = 1'b0;
  logic [15:0] mask_ld_data = '0;
  logic        legacy_ld = 1'b0;
  logic [3:0]  legacy_idx = '0;
  logic        mm_we = 1'b0;
  logic [15:0] mm_addr = '0;
  logic [7:0]  mm_wdata = '0;
  logic        draw_start = 1'b0;
  logic        pix_valid = 1'b0;
  logic [3:0]  src_idx = '0;
  logic [3:0]  dst_idx = '0;
  logic        pix_hit, collided;

  int    checks = 0, failures = 0;
  string phase = "R1";
  bit    done = 1'b0;

  logic [15:0] m_mask;
  logic        m_hit, m_coll;

  always #(CLK_PERIOD/2) clk = ~clk;

  bgmask_collide u_bgmask_collide (.*);

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = 16'h0001; m_hit = 0; m_coll = 0;
    end else begin
      m_hit  = pix_valid && (m_mask[src_idx] == 0) && (m_mask[dst_idx] == 0);
      m_coll = (draw_start ? 1'b0 : m_coll) | m_hit;
      if (mask_ld) m_mask = mask_ld_data;
      else if (legacy_ld) m_mask = 16'h0001 << legacy_idx;
      else if (mm_we && mm_addr == 16'hFFF4) m_mask[7:0] = mm_wdata;
      else if (mm_we && mm_addr == 16'hFFF5) m_mask[15:8] = mm_wdata;
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) if (!done && $time > CLK_PERIOD) begin
    checks += 2;
    if (pix_hit !== m_hit) begin
      failures++;
      $display("FAIL %s pix_hit act=%b exp=%b t=%0t", phase, pix_hit, m_hit, $time);
    end
    if (collided !== m_coll) begin
      failures++;
      $display("FAIL %s collided act=%b exp=%b t=%0t", phase, collided, m_coll, $time);
    end
  end

  task automatic tick();
    @(negedge clk);
    mask_ld = 0; legacy_ld = 0; mm_we = 0; draw_start = 0; pix_valid = 0;
  endtask

  task automatic pair(input int s, input int d);
    pix_valid = 1; src_idx = 4'(s); dst_idx = 4'(d); tick();
  endtask

  task automatic sweep();
    for (int s = 0; s < 16; s++)
      for (int d = 0; d < 16; d++) pair(s, d);
    tick();
  endtask

  task automatic mmw(input logic [15:0] a, input logic [7:0] v);
    mm_we = 1; mm_addr = a; mm_wdata = v; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, index 0 is the only background
    phase = "R1"; tick();
    pair(0, 5); pair(5, 0); pair(3, 5); tick();
    // R2: all pairs under the reset mask
    phase = "R2"; draw_start = 1; tick(); sweep();
    // R3: full-width load
    phase = "R3"; mask_ld = 1; mask_ld_data = 16'hF0F0; tick(); sweep();
    mask_ld = 1; mask_ld_data = 16'hFFFF; tick(); draw_start = 1; tick(); sweep();
    // R4: legacy one-color command
    phase = "R4"; legacy_ld = 1; legacy_idx = 4'd7; tick(); draw_start = 1; tick(); sweep();
    legacy_ld = 1; legacy_idx = 4'd15; tick(); sweep();
    // R5: byte lanes
    phase = "R5"; mask_ld = 1; mask_ld_data = 16'h0000; tick();
    mmw(16'hFFF4, 8'hA5); sweep();
    mmw(16'hFFF5, 8'h3C); sweep();
    mmw(16'hFFF4, 8'h00); sweep();
    // R6: neighbouring and aliased addresses
    phase = "R6"; mmw(16'hFFF3, 8'hFF); mmw(16'hFFF6, 8'hFF); mmw(16'h00F4, 8'hFF);
    mmw(16'h7FF5, 8'hFF); sweep();
    // R7: sticky flag across draws
    phase = "R7"; mask_ld = 1; mask_ld_data = 16'h0001; tick();
    draw_start = 1; tick(); pair(0, 0); pair(0, 3); pair(2, 0); tick(); tick();
    pair(2, 3); pair(0, 0); tick(); tick();
    draw_start = 1; tick(); tick();
    draw_start = 1; pix_valid = 1; src_idx = 4; dst_idx = 9; tick(); tick(); tick();
    draw_start = 1; pix_valid = 1; src_idx = 0; dst_idx = 9; tick(); pair(1, 1); tick();
    // R8: priority and same-cycle write
    phase = "R8";
    mask_ld = 1; mask_ld_data = 16'h00FF; legacy_ld = 1; legacy_idx = 4'd9;
    mm_we = 1; mm_addr = 16'hFFF5; mm_wdata = 8'hFF; tick(); sweep();
    legacy_ld = 1; legacy_idx = 4'd2; mm_we = 1; mm_addr = 16'hFFF4; mm_wdata = 8'hFF; tick(); sweep();
    mask_ld = 1; mask_ld_data = 16'hFFFF; pix_valid = 1; src_idx = 5; dst_idx = 6; tick();
    pair(5, 6);
    mask_ld = 1; mask_ld_data = 16'h0000; pix_valid = 1; src_idx = 5; dst_idx = 6; tick();
    pair(5, 6); tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule